// File: doc/BRIEF.md
# ALU Status Flag Generator

This block forms the new processor status byte after an 8-bit arithmetic or logic operation. The adder sits outside it and supplies its result, carry-out and carry out of bit 3. The block also receives both operands, a three-bit operation class and the current status byte. From these it derives the carry, zero, negative, overflow, sign and half-carry flags. The interrupt-enable bit and the bit-transfer bit pass through unchanged.

Increment and decrement take their overflow from the operand value alone. They keep the old carry and half-carry, so a loop counter can step between the bytes of a multi-byte sum without disturbing the carry chain. Logic operations clear overflow and keep both carry bits.

The block is one register stage with a valid/ready handshake on each side. An update is accepted when `in_valid` and `in_ready` are both high. The new status byte is held on `out_sreg` with `out_valid` high until the consumer raises `out_ready`. While the output is stalled, `in_ready` is low, so back-pressure passes straight upstream. A new update can be accepted in the same cycle the held one drains.

Top module: `alu_status_flags`

## Requirements
- R1: An update is accepted at a clock edge where `in_valid` and `in_ready` are both high. From the following cycle, `out_valid` is high and `out_sreg` carries the computed status. `in_ready` equals `!out_valid || out_ready`.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_sreg` holds its value, and `in_ready` is low.
- R3: Status bit 1 (zero) is set exactly when `in_res` is all zeros. This applies to operation classes 0 to 4.
- R4: Status bit 2 (negative) equals bit 7 of `in_res` for operation classes 0 to 4.
- R5: For class 0 (add), bit 3 (overflow) is set when both operands have bit 7 equal and the result's bit 7 differs from them. Bit 0 takes `in_carry` and bit 5 takes `in_half`.
- R6: For class 1 (subtract/compare), bit 3 is set when the operands' bit 7 values differ and the result's bit 7 differs from operand A's. Bit 0 takes `in_carry` and bit 5 takes `in_half`.
- R7: For class 2 (increment), bit 3 is set only when `in_a` is 0x7F. Bits 0 and 5 keep their values from `in_sreg`.
- R8: For class 3 (decrement), bit 3 is set only when `in_a` is 0x80. Bits 0 and 5 keep their values from `in_sreg`.
- R9: For class 4 (logic), bit 3 is cleared and bits 0 and 5 keep their values from `in_sreg`.
- R10: For classes 0 to 4, status bit 4 (sign) equals bit 2 XOR bit 3 of the new status.
- R11: Bits 7 and 6 are always copied from `in_sreg`. Classes 5 to 7 return `in_sreg` unchanged.
- R12: After reset, `out_valid` is low and `out_sreg` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Update request present |
| in_ready | output | 1 | Block can take an update |
| in_op | input | 3 | Operation class (0 add, 1 sub, 2 inc, 3 dec, 4 logic) |
| in_a | input | 8 | Operand A |
| in_b | input | 8 | Operand B |
| in_res | input | 8 | Adder or logic result |
| in_carry | input | 1 | Carry/borrow out of the adder |
| in_half | input | 1 | Carry/borrow out of bit 3 |
| in_sreg | input | 8 | Current status byte |
| out_valid | output | 1 | Updated status present |
| out_ready | input | 1 | Consumer takes the status |
| out_sreg | output | 8 | Updated status byte |

## Verification
A wrong overflow term reaches the port in the cycle after acceptance. It shows in two bits at once: bit 3, and the sign bit, which depends on it. The operand-boundary vectors for each class (0x7F, 0x80, carry and no carry) expose it directly. A faulty holding register would let `out_sreg` change during a stall or drop an update. A stalled transfer that is followed by a competing offer catches either fault on the first edge after the stall. Preserved carry and half-carry are checked against old status values that differ from the adder's inputs.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_INC   = 3'd2,
    OP_DEC   = 3'd3,
    OP_LOGIC = 3'd4
  } op_class_e;

  localparam int SR_W  = 8;
  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_N = 2;
  localparam int BIT_V = 3;
  localparam int BIT_S = 4;
  localparam int BIT_H = 5;
endpackage

// File: rtl/alu_flag_ovf.sv
module alu_flag_ovf
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  output logic              v
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    case (op)
      OP_ADD:  v = (a[MSB] & b[MSB] & ~r[MSB]) | (~a[MSB] & ~b[MSB] & r[MSB]);
      OP_SUB:  v = (a[MSB] & ~b[MSB] & ~r[MSB]) | (~a[MSB] & b[MSB] & r[MSB]);
      OP_INC:  v = (a == MAX_POS);
      OP_DEC:  v = (a == MIN_NEG);
      default: v = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  input  logic              carry,
  input  logic              half,
  input  logic [SR_W-1:0]   sreg_in,
  output logic [SR_W-1:0]   sreg_out
);
  logic v_flag;
  logic n_flag;
  logic z_flag;
  logic takes_carry;
  logic known_op;

  alu_flag_ovf #(.DATA_W(DATA_W)) u_ovf (
    .op (op),
    .a  (a),
    .b  (b),
    .r  (r),
    .v  (v_flag)
  );

  assign n_flag      = r[DATA_W-1];
  assign z_flag      = (r == '0);
  assign takes_carry = (op == OP_ADD) || (op == OP_SUB);
  assign known_op    = (op <= OP_LOGIC);

  always_comb begin
    sreg_out = sreg_in;
    if (known_op) begin
      sreg_out[BIT_Z] = z_flag;
      sreg_out[BIT_N] = n_flag;
      sreg_out[BIT_V] = v_flag;
      sreg_out[BIT_S] = n_flag ^ v_flag;
      if (takes_carry) begin
        sreg_out[BIT_C] = carry;
        sreg_out[BIT_H] = half;
      end
    end
  end
endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_res,
  input  logic              in_carry,
  input  logic              in_half,
  input  logic [7:0]        in_sreg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_sreg
);
  logic [SR_W-1:0] next_sreg;
  logic            accept;

  alu_flag_core #(.DATA_W(DATA_W)) u_core (
    .op       (in_op),
    .a        (in_a),
    .b        (in_b),
    .r        (in_res),
    .carry    (in_carry),
    .half     (in_half),
    .sreg_in  (in_sreg),
    .sreg_out (next_sreg)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sreg  <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_sreg  <= next_sreg;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alu_status_flags_chk.sv
module alu_status_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [DATA_W-1:0] in_res,
  input logic [7:0]        in_sreg,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_sreg
);
  logic take;
  assign take = in_valid && in_ready;

  // R1
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R2
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sreg)));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op <= 3'd4) |=> (out_sreg[1] == ($past(in_res) == '0)));

  // R4
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op <= 3'd4) |=> (out_sreg[2] == $past(in_res[DATA_W-1])));

  // R7
  step_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_op == 3'd2 || in_op == 3'd3)) |=> (out_sreg[0] == $past(in_sreg[0])));

  // R9
  logic_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 3'd4) |=> !out_sreg[3]);

  // R10
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op <= 3'd4) |=> (out_sreg[4] == (out_sreg[2] ^ out_sreg[3])));

  // R11
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_sreg[7:6] == $past(in_sreg[7:6])));
endmodule

bind alu_status_flags alu_status_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_res    (in_res),
  .in_sreg   (in_sreg),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sreg  (out_sreg)
);

// File: tb/alu_status_flags_tb.sv
`timescale 1ns/1ps
module alu_status_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_op = '0;
  logic [7:0] in_a = '0, in_b = '0, in_res = '0, in_sreg = '0;
  logic       in_carry = 1'b0, in_half = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_sreg;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  alu_status_flags u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_res(in_res),
    .in_carry(in_carry), .in_half(in_half), .in_sreg(in_sreg),
    .out_valid(out_valid), .out_ready(out_ready), .out_sreg(out_sreg)
  );

  // {op, a, b, res, carry, half, old status, expected status}
  localparam int NV = 15;
  localparam logic [44:0] VEC [NV] = '{
    {3'd0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1, 8'h00, 8'h2C}, // R5 positive overflow
    {3'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1, 8'hC0, 8'hE3}, // R5 R3 R11 carry, zero
    {3'd0, 8'h80, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, 8'h1B}, // R5 R10 negative overflow
    {3'd1, 8'h80, 8'h01, 8'h7F, 1'b0, 1'b1, 8'h00, 8'h38}, // R6 overflow, sign
    {3'd1, 8'h05, 8'h05, 8'h00, 1'b0, 1'b0, 8'h3F, 8'h02}, // R6 R3 equal compare
    {3'd1, 8'h01, 8'h02, 8'hFF, 1'b1, 1'b1, 8'h40, 8'h75}, // R6 R4 borrow
    {3'd1, 8'h7F, 8'hFF, 8'h80, 1'b1, 1'b0, 8'h00, 8'h0D}, // R6 pos minus neg
    {3'd2, 8'h7F, 8'h00, 8'h80, 1'b0, 1'b1, 8'h01, 8'h0D}, // R7 overflow, C kept
    {3'd2, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1, 8'h20, 8'h22}, // R7 wrap, H kept
    {3'd3, 8'h80, 8'h00, 8'h7F, 1'b1, 1'b1, 8'h00, 8'h18}, // R8 overflow
    {3'd3, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0, 8'h21, 8'h35}, // R8 wrap, C H kept
    {3'd4, 8'hF0, 8'h0F, 8'h00, 1'b1, 1'b1, 8'h08, 8'h02}, // R9 V cleared
    {3'd4, 8'hFF, 8'h80, 8'h80, 1'b0, 1'b0, 8'hE9, 8'hF5}, // R9 R10 keep C H
    {3'd5, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 8'h5A, 8'h5A}, // R11 reserved class
    {3'd7, 8'h7F, 8'h80, 8'hFF, 1'b1, 1'b1, 8'hA5, 8'hA5}  // R11 reserved class
  };
  localparam int RQ [NV] = '{5, 5, 5, 6, 6, 6, 6, 7, 7, 8, 8, 9, 9, 11, 11};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [44:0] v);
    @(negedge clk);
    in_op    = v[44:42];
    in_a     = v[41:34];
    in_b     = v[33:26];
    in_res   = v[25:18];
    in_carry = v[17];
    in_half  = v[16];
    in_sreg  = v[15:8];
    in_valid = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    // R12 reset state
    check("R12 out_valid", {7'd0, out_valid}, 8'h00);
    check("R12 out_sreg", out_sreg, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 in_ready idle", {7'd0, in_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      check("R1 valid", {7'd0, out_valid}, 8'h01);
      check($sformatf("R%0d vec %0d", RQ[i], i), out_sreg, VEC[i][7:0]);
    end

    // R1 output drains when nothing new is offered
    @(posedge clk);
    #1;
    check("R1 drain", {7'd0, out_valid}, 8'h00);

    // R2 stall: hold first update, offer a competing one
    @(negedge clk);
    out_ready = 1'b0;
    drive(VEC[0]);
    @(posedge clk);
    #1;
    check("R2 first taken", out_sreg, 8'h2C);
    drive(VEC[1]);
    #1;
    check("R2 in_ready low", {7'd0, in_ready}, 8'h00);
    @(posedge clk);
    #1;
    check("R2 held", out_sreg, 8'h2C);
    check("R2 valid held", {7'd0, out_valid}, 8'h01);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R1 in_ready on drain", {7'd0, in_ready}, 8'h01);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check("R2 second after release", out_sreg, 8'hE3);

    // R7 R8 decrement/increment at non-boundary values: no overflow
    drive({3'd2, 8'h10, 8'h00, 8'h11, 1'b0, 1'b0, 8'h21, 8'h21});
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check("R7 inc no V", out_sreg, 8'h21);
    drive({3'd3, 8'h7F, 8'h00, 8'h7E, 1'b1, 1'b1, 8'h00, 8'h00});
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check("R8 dec 0x7F no V", out_sreg, 8'h00);

    // R12 reset again clears held state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R12 reset valid", {7'd0, out_valid}, 8'h00);
    check("R12 reset sreg", out_sreg, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule